// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a 2048 x 8 true dual-port memory shared by two processors, called the left side and the right side. Each side owns a chip enable, a write enable, an address, write data and registered read data, and either side may read or write any location at any time. Both sides run on one shared clock.

When both sides select the same location in the same cycle, the block decides which side came second. The second side is the one whose enable was asserted more recently. If both enables went high in the same cycle, the right side counts as second. A write from the second side is dropped without any indication to either side. Reads are never blocked, and a read always returns the contents from before the edge.

The two highest locations also act as doorbells. The right side raises an interrupt to the left side by writing the second-highest location, and the left side raises an interrupt to the right side by writing the highest location. The receiving side lowers its interrupt by accessing that same location. Both doorbell locations still store data like any other location.

Top module: `mbox_dpram`

## Requirements
- R1: A write by either side (ce=1, we=1) stores the data. A read (ce=1, we=0) of that location by either side in a later cycle shows the data on that side's read output one clock after the address is presented. While ce=0, a side's read output holds its value.
- R2: When a location is written in the same cycle that either side reads it, the read returns the value stored before that edge.
- R3: When both sides select the same address in one cycle, the side whose enable rose in this cycle while the other side's enable was already high is the later side. A write from the later side is dropped, and the earlier side's write is stored.
- R4: When both enables rise in the same cycle on the same address, the left side's write is stored and the right side's write is dropped.
- R5: The enable order persists while both enables stay high. In each following same-address cycle, the side that asserted its enable later continues to lose.
- R6: When the two sides write different addresses in the same cycle, both writes are stored.
- R7: A stored right-side write to address 0x7FE sets `l_irq` at the next edge. Any left-side access (read or write) to 0x7FE clears `l_irq` at the next edge. If a set and a clear happen in the same cycle, the set wins.
- R8: A stored left-side write to address 0x7FF sets `r_irq` at the next edge. Any right-side access to 0x7FF clears it. If both happen in the same cycle, the set wins.
- R9: Addresses 0x7FE and 0x7FF keep the data written to them. A read of a doorbell location by the side that sets it leaves the interrupt unchanged.
- R10: During and right after reset, `l_irq`, `r_irq`, `l_rdata` and `r_rdata` are all zero.
- R11: A dropped write to a doorbell location neither sets the interrupt nor changes the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_ce | input | 1 | Left side enable |
| l_we | input | 1 | Left side write enable |
| l_addr | input | 11 | Left side address |
| l_wdata | input | 8 | Left side write data |
| l_rdata | output | 8 | Left side read data, one clock latency |
| l_irq | output | 1 | Interrupt to left side, active high |
| r_ce | input | 1 | Right side enable |
| r_we | input | 1 | Right side write enable |
| r_addr | input | 11 | Right side address |
| r_wdata | input | 8 | Right side write data |
| r_rdata | output | 8 | Right side read data, one clock latency |
| r_irq | output | 1 | Interrupt to right side, active high |

## Verification
The storage path is exercised with writes and reads on separate cycles, with one side reading while the other writes the same location, and with both sides writing different addresses in one cycle. These patterns separate correct storage from a write-through or a lost-write fault. Same-address writes are exercised in three enable orders: the right side held first, both enables rising together, and both enables held across several cycles. These orders separate the arbitration rule from a fixed-priority scheme or from a scheme that forgets who arrived first. The doorbells are exercised by setting each one, reading it from the setting side, clearing it from the receiving side, colliding a set with a clear, and colliding a dropped write with a clear. These cases show that only stored writes raise an interrupt.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Order state: 1 means the left side asserted its enable after the right side.
  function automatic logic left_is_newer(input logic l_rise, input logic r_rise,
                                         input logic prev);
    if (l_rise && !r_rise)      return 1'b1;
    else if (r_rise && !l_rise) return 1'b0;
    else if (l_rise && r_rise)  return 1'b0;  // simultaneous: left treated as older
    else                        return prev;
  endfunction

  // A write lands when the side is enabled, writing and not the losing side.
  function automatic logic write_lands(input logic ce, input logic we,
                                       input logic inhibit);
    return ce && we && !inhibit;
  endfunction

  // Doorbell next state: set dominates clear.
  function automatic logic bell_next(input logic cur, input logic set,
                                     input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/mbox_order.sv
module mbox_order
  import mbox_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_ce,
  input  logic l_we,
  input  logic r_ce,
  input  logic r_we,
  input  logic same_addr,
  output logic inhibit_l,
  output logic inhibit_r
);

  logic l_ce_q, r_ce_q, newer_q;
  logic l_rise, r_rise, newer_now, collide;

  assign l_rise    = l_ce && !l_ce_q;
  assign r_rise    = r_ce && !r_ce_q;
  assign newer_now = left_is_newer(l_rise, r_rise, newer_q);
  assign collide   = l_ce && r_ce && same_addr;
  assign inhibit_l = collide && l_we && newer_now;
  assign inhibit_r = collide && r_we && !newer_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_ce_q  <= 1'b0;
      r_ce_q  <= 1'b0;
      newer_q <= 1'b0;
    end else begin
      l_ce_q  <= l_ce;
      r_ce_q  <= r_ce;
      newer_q <= newer_now;
    end
  end

  assert_one_loser_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(inhibit_l && inhibit_r));

  assert_tie_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rise && r_rise && collide && l_we) |-> !inhibit_l);

  assert_late_left_loses_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rise && !r_rise && collide && l_we) |-> inhibit_l);

  assert_apart_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !same_addr |-> (!inhibit_l && !inhibit_r));

  assert_order_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce && r_ce) ##1 (l_ce && r_ce && collide && r_we && !l_rise && !r_rise)
      |-> (inhibit_r == !$past(newer_now)));

endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_ce,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (l_wr) mem[l_addr] <= l_wdata;
    if (r_wr) mem[r_addr] <= r_wdata;
  end

  // Read-first: the array value sampled at the edge is the pre-write value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_ce) l_rdata <= mem[l_addr];
      if (r_ce) r_rdata <= mem[r_addr];
    end
  end

  assert_l_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !l_ce |=> $stable(l_rdata));

  assert_r_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !r_ce |=> $stable(r_rdata));

  assert_no_double_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && r_wr) |-> (l_addr != r_addr));

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
  import mbox_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= bell_next(irq, set, clr);
  end

  assert_set_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq);

  assert_clear_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !irq);

  assert_idle_hold_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(irq));

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BELL_TO_L = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] BELL_TO_R = ADDR_W'(DEPTH - 1);
  localparam int SIDES = 2;

  // Named internal events
  logic same_addr, inhibit_l, inhibit_r, l_lands, r_lands;
  logic [SIDES-1:0] bell_set, bell_clr, bell_irq;

  assign same_addr = (l_addr == r_addr);
  assign l_lands   = write_lands(l_ce, l_we, inhibit_l);
  assign r_lands   = write_lands(r_ce, r_we, inhibit_r);

  // index 0: interrupt to left side, index 1: interrupt to right side
  assign bell_set[0] = r_lands && (r_addr == BELL_TO_L);
  assign bell_clr[0] = l_ce && (l_addr == BELL_TO_L);
  assign bell_set[1] = l_lands && (l_addr == BELL_TO_R);
  assign bell_clr[1] = r_ce && (r_addr == BELL_TO_R);

  mbox_order u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .l_ce      (l_ce),
    .l_we      (l_we),
    .r_ce      (r_ce),
    .r_we      (r_we),
    .same_addr (same_addr),
    .inhibit_l (inhibit_l),
    .inhibit_r (inhibit_r)
  );

  mbox_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_ce    (l_ce),
    .l_wr    (l_lands),
    .l_addr  (l_addr),
    .l_wdata (l_wdata),
    .l_rdata (l_rdata),
    .r_ce    (r_ce),
    .r_wr    (r_lands),
    .r_addr  (r_addr),
    .r_wdata (r_wdata),
    .r_rdata (r_rdata)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_bell
    mbox_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (bell_set[s]),
      .clr   (bell_clr[s]),
      .irq   (bell_irq[s])
    );
  end

  assign l_irq = bell_irq[0];
  assign r_irq = bell_irq[1];

  assert_dropped_no_bell_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_l && !l_irq && !r_irq) |=> !r_irq);

  assert_reader_keeps_bell_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce && !l_we && l_addr == BELL_TO_R && !bell_clr[1]) |=> $stable(r_irq));

endmodule

// File: tb/mbox_dpram_tb_top.sv
`timescale 1ns/100ps
module mbox_dpram_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
  logic [10:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0;
  logic [7:0]  l_rdata, r_rdata;
  logic        l_irq, r_irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  mbox_dpram dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_irq(l_irq),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_irq(r_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus (inputs change on the falling edge).
  task automatic step(input logic lce, input logic lwe, input logic [10:0] la,
                      input logic [7:0] ld, input logic rce, input logic rwe,
                      input logic [10:0] ra, input logic [7:0] rd);
    l_ce = lce; l_we = lwe; l_addr = la; l_wdata = ld;
    r_ce = rce; r_we = rwe; r_addr = ra; r_wdata = rd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 11'h0, 8'h0, 0, 0, 11'h0, 8'h0);
  endtask

  task automatic rd_left(input logic [10:0] a, input logic [7:0] exp, input string req);
    step(1, 0, a, 8'h0, 0, 0, 11'h0, 8'h0);
    check(req, l_rdata, exp);
    idle();
  endtask

  task automatic rd_right(input logic [10:0] a, input logic [7:0] exp, input string req);
    step(0, 0, 11'h0, 8'h0, 1, 0, a, 8'h0);
    check(req, r_rdata, exp);
    idle();
  endtask

  task automatic t_reset();
    check("R10 l_irq", {7'b0, l_irq}, 8'h0);
    check("R10 r_irq", {7'b0, r_irq}, 8'h0);
    check("R10 l_rdata", l_rdata, 8'h0);
    check("R10 r_rdata", r_rdata, 8'h0);
  endtask

  task automatic t_basic();
    step(1, 1, 11'h005, 8'hA5, 0, 0, 11'h0, 8'h0); idle();
    rd_right(11'h005, 8'hA5, "R1 left write right read");
    step(0, 0, 11'h0, 8'h0, 1, 1, 11'h123, 8'h3C); idle();
    rd_left(11'h123, 8'h3C, "R1 right write left read");
    check("R1 rdata held while idle", l_rdata, 8'h3C);
  endtask

  task automatic t_read_first();
    step(1, 1, 11'h010, 8'h11, 0, 0, 11'h0, 8'h0); idle();
    step(1, 1, 11'h010, 8'h22, 1, 0, 11'h010, 8'h0);
    check("R2 read sees old value", r_rdata, 8'h11);
    idle();
    rd_right(11'h010, 8'h22, "R2 new value after");
  endtask

  task automatic t_late_left();
    step(0, 0, 11'h0, 8'h0, 1, 1, 11'h020, 8'h33);
    step(1, 1, 11'h020, 8'h55, 1, 1, 11'h020, 8'h44);
    idle();
    rd_left(11'h020, 8'h44, "R3 later left write dropped");
  endtask

  task automatic t_tie();
    step(1, 1, 11'h030, 8'h66, 1, 1, 11'h030, 8'h77);
    idle();
    rd_right(11'h030, 8'h66, "R4 tie left wins");
  endtask

  task automatic t_hold();
    step(1, 1, 11'h040, 8'h01, 1, 1, 11'h040, 8'h02);
    step(1, 1, 11'h040, 8'h03, 1, 1, 11'h040, 8'h04);
    idle();
    rd_left(11'h040, 8'h03, "R5 held tie left keeps winning");
    step(0, 0, 11'h0, 8'h0, 1, 1, 11'h050, 8'h10);
    step(1, 1, 11'h050, 8'h20, 1, 1, 11'h050, 8'h30);
    step(1, 1, 11'h050, 8'h21, 1, 1, 11'h050, 8'h31);
    idle();
    rd_left(11'h050, 8'h31, "R5 held right keeps winning");
  endtask

  task automatic t_apart();
    step(1, 1, 11'h060, 8'hAB, 1, 1, 11'h061, 8'hCD);
    idle();
    rd_left(11'h061, 8'hCD, "R6 right write kept");
    rd_right(11'h060, 8'hAB, "R6 left write kept");
  endtask

  task automatic t_bell_left();
    step(0, 0, 11'h0, 8'h0, 1, 1, 11'h7FE, 8'h5A);
    check("R7 l_irq set", {7'b0, l_irq}, 8'h1);
    check("R7 r_irq untouched", {7'b0, r_irq}, 8'h0);
    idle();
    rd_right(11'h7FE, 8'h5A, "R9 data at 0x7FE");
    check("R9 setter read keeps l_irq", {7'b0, l_irq}, 8'h1);
    step(1, 0, 11'h7FE, 8'h0, 0, 0, 11'h0, 8'h0);
    check("R7 l_irq cleared by left access", {7'b0, l_irq}, 8'h0);
    check("R9 left reads 0x7FE", l_rdata, 8'h5A);
    idle();
  endtask

  task automatic t_bell_right();
    step(1, 1, 11'h7FF, 8'hA7, 0, 0, 11'h0, 8'h0);
    check("R8 r_irq set", {7'b0, r_irq}, 8'h1);
    idle();
    rd_left(11'h7FF, 8'hA7, "R9 data at 0x7FF");
    check("R9 setter read keeps r_irq", {7'b0, r_irq}, 8'h1);
    step(0, 0, 11'h0, 8'h0, 1, 0, 11'h7FF, 8'h0);
    check("R8 r_irq cleared by right access", {7'b0, r_irq}, 8'h0);
    idle();
  endtask

  task automatic t_set_wins();
    step(0, 0, 11'h0, 8'h0, 1, 0, 11'h000, 8'h0);
    step(1, 0, 11'h7FE, 8'h0, 1, 1, 11'h7FE, 8'hC3);
    check("R7 set wins over clear", {7'b0, l_irq}, 8'h1);
    idle();
    step(1, 0, 11'h7FE, 8'h0, 0, 0, 11'h0, 8'h0);
    check("R7 cleared after", {7'b0, l_irq}, 8'h0);
    check("R7 stored 0xC3", l_rdata, 8'hC3);
    idle();
  endtask

  task automatic t_dropped_bell();
    step(0, 0, 11'h0, 8'h0, 1, 0, 11'h001, 8'h0);
    step(1, 1, 11'h7FF, 8'hEE, 1, 0, 11'h7FF, 8'h0);
    check("R11 dropped write no r_irq", {7'b0, r_irq}, 8'h0);
    idle();
    rd_right(11'h7FF, 8'hA7, "R11 0x7FF unchanged");
  endtask

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_read_first();
    t_late_left();
    t_tie();
    t_hold();
    t_apart();
    t_bell_left();
    t_bell_right();
    t_set_wins();
    t_dropped_bell();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule